// File: doc/BRIEF.md
# Serial Memory Two-Wire Target Engine

This block is the protocol front end of a byte-wide serial memory of 4K or 8K locations, reached over a two-wire bus (I2C style). It oversamples the clock and data lines with the core clock and rejects short spikes on both. It then recognises start and stop conditions and moves 8-bit words, most significant bit first. It answers only to its own device word. That word carries a fixed type code and three address bits set by strap pins.

On a write, two memory address bytes follow the device word, and every data byte after them goes to a page-write engine together with its target address. A stop condition sends one commit pulse, which starts the timed programming. While the engine reports busy, the block refuses its device word. A master therefore learns that the write cycle is done when its device word is acknowledged again.

On a read, the block presents its address pointer on a read port and shifts the returned byte onto the bus. It continues to the next address as long as the master acknowledges. The pad driver, the array and the programming timer are outside the block.

Top module: `smi_target`

## Requirements
- R1: A pulse on the clock or data line that lasts fewer than FILT_N core clocks is ignored, and longer levels pass through after a fixed delay.
- R2: Data falling while the clock is high is a start and data rising while the clock is high is a stop. A start at any point abandons the current transfer and expects a new device word.
- R3: The device word is, MSB first, the code 1010, three bits that must equal `strap_i[2:0]`, and a direction bit (1 = read, 0 = write). A matching word is acknowledged by pulling data low in the ninth clock. Any other word gets no acknowledge and the block waits for the next start.
- R4: While `busy_i` is high, a device word gets no acknowledge, whatever its direction bit.
- R5: After a write device word, two address bytes follow, high byte first, and each is acknowledged. Bits of the high byte above the ADDR_W-bit array address are ignored.
- R6: Each write data byte is acknowledged and produces one `wr_valid_o` pulse carrying the pointer address and the byte. Between bytes the pointer steps only in its low log2(PAGE_BYTES) bits and wraps within the page.
- R7: `wr_commit_o` pulses once on a stop that ends a write carrying at least one data byte. A write that stops after the device word or the address bytes does not commit.
- R8: The address pointer is 0 after reset. It always holds the last accessed address plus one: after a read with a full-array wrap, after a write with a page wrap. A read without address bytes starts at the pointer.
- R9: A write device word, two address bytes, a repeated start and a read device word return data from the address just loaded.
- R10: Read bytes are shifted out MSB first. A master acknowledge (0) in the ninth clock moves on to the next address, which wraps from the last location to 0.
- R11: After a master no-acknowledge the block releases the data line and drives nothing until the next start.
- R12: The block changes its data-line drive only while the filtered clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| strap_i | input | 3 | Board-level device address bits |
| busy_i | input | 1 | Page-write engine is programming |
| rd_data_i | input | 8 | Array byte at `rd_addr_o` |
| sda_oe_o | output | 1 | 1 = pull the data line low |
| rd_addr_o | output | ADDR_W | Current address pointer |
| wr_valid_o | output | 1 | One-cycle pulse: a write byte is presented |
| wr_addr_o | output | ADDR_W | Address of the presented write byte |
| wr_data_o | output | 8 | Presented write byte |
| wr_commit_o | output | 1 | One-cycle pulse: start programming the buffered page |

## Verification
The assertions assume that the bus obeys the two-wire rules once filtered. The master moves the data line only while the clock is low, except when it makes a start or stop, and it never makes a start or stop while the block holds the line low. Every clock phase must last well beyond the filter delay of FILT_N+2 core clocks, so that the read byte is stable before the master samples it. The bench drives a bus master whose quarter bit lasts 30 core clocks, twice the filter delay. It changes data only in the low phase, and the only violations it creates are spikes shorter than the filter length, used to exercise R1.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD,
    ST_MACK
  } smi_state_e;
endpackage

// File: rtl/smi_deglitch.sv
module smi_deglitch #(
  parameter int FILT_N  = 13,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CNT_W = (FILT_N > 1) ? $clog2(FILT_N) : 1;

  logic [1:0]       sync_q;
  logic             filt_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {2{RST_VAL}};
      filt_q <= RST_VAL;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_W'(FILT_N - 1)) begin
        filt_q <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign filt_o = filt_q;

  AST_FILT_FOLLOWS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_q != $past(filt_q)) |-> ($past(sync_q[1]) == filt_q)); // R1
endmodule

// File: rtl/smi_bus_events.sv
module smi_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = !scl_q && scl_i;
  assign scl_fall_o = scl_q && !scl_i;
  assign start_o    = scl_q && scl_i && sda_q && !sda_i;
  assign stop_o     = scl_q && scl_i && !sda_q && sda_i;

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({scl_rise_o, scl_fall_o, start_o, stop_o})); // R2
endmodule

// File: rtl/smi_addr_ptr.sv
module smi_addr_ptr #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              step_page_i,
  input  logic              step_full_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;
  logic [PAGE_W-1:0] low_nxt;

  assign low_nxt = ptr_q[PAGE_W-1:0] + PAGE_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (load_i) begin
      ptr_q <= load_val_i;
    end else if (step_page_i) begin
      ptr_q <= {ptr_q[ADDR_W-1:PAGE_W], low_nxt};
    end else if (step_full_i) begin
      ptr_q <= ptr_q + ADDR_W'(1);
    end
  end

  assign ptr_o = ptr_q;

  AST_PAGE_STEP_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_page_i && !load_i) |=> (ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W]))); // R6
  AST_FULL_STEP_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_full_i && !step_page_i && !load_i && (ptr_q == {ADDR_W{1'b1}})) |=> (ptr_q == '0)); // R10
endmodule

// File: rtl/smi_target.sv
module smi_target
  import smi_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32,
  parameter int FILT_N     = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  input  logic [7:0]        rd_data_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  // filtered bus lines: index 0 = clock, 1 = data
  logic [1:0] raw_lines, flt_lines;
  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_flt
    smi_deglitch #(.FILT_N(FILT_N), .RST_VAL(1'b1)) u_flt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw_lines[g]),
      .filt_o (flt_lines[g])
    );
  end

  logic scl_f, sda_f;
  assign scl_f = flt_lines[0];
  assign sda_f = flt_lines[1];

  logic scl_rise, scl_fall, start_ev, stop_ev;

  smi_bus_events u_ev (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_f),
    .sda_i      (sda_f),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  smi_state_e        st_q, st_d;
  logic [7:0]        sh_q, sh_d, hi_q, hi_d;
  logic [3:0]        cnt_q, cnt_d;
  logic              ack_q, ack_d, oe_q, oe_d, any_q, any_d, mack_q, mack_d;
  logic              wv_q, wv_d, commit_q, commit_d;
  logic [ADDR_W-1:0] wa_q, wa_d;
  logic [7:0]        wd_q, wd_d;
  logic              p_load, p_page, p_full;
  logic [ADDR_W-1:0] p_val, ptr;
  logic              byte_full;
  logic              dev_ok;

  assign byte_full = (cnt_q == 4'd8);
  assign p_val     = ADDR_W'({hi_q, sh_q});
  assign dev_ok    = (sh_q[7:4] == DEV_CODE) && (sh_q[3:1] == strap_i) && !busy_i;

  smi_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (p_load),
    .load_val_i  (p_val),
    .step_page_i (p_page),
    .step_full_i (p_full),
    .ptr_o       (ptr)
  );

  always_comb begin
    st_d     = st_q;
    sh_d     = sh_q;
    hi_d     = hi_q;
    cnt_d    = cnt_q;
    ack_d    = ack_q;
    oe_d     = oe_q;
    any_d    = any_q;
    mack_d   = mack_q;
    wv_d     = 1'b0;
    wa_d     = wa_q;
    wd_d     = wd_q;
    commit_d = 1'b0;
    p_load   = 1'b0;
    p_page   = 1'b0;
    p_full   = 1'b0;

    if (start_ev) begin
      st_d  = ST_DEV;
      cnt_d = '0;
      ack_d = 1'b0;
      oe_d  = 1'b0;
      any_d = 1'b0;
    end else if (stop_ev) begin
      commit_d = (st_q == ST_WR) && any_q;
      st_d     = ST_IDLE;
      ack_d    = 1'b0;
      oe_d     = 1'b0;
      any_d    = 1'b0;
    end else if (ack_q) begin
      // ninth clock of a received byte: hold the acknowledge until it ends
      if (scl_fall) begin
        ack_d = 1'b0;
        cnt_d = '0;
        if (st_q == ST_RD) begin
          sh_d = rd_data_i;
          oe_d = !rd_data_i[7];
        end else begin
          oe_d = 1'b0;
        end
      end
    end else begin
      case (st_q)
        ST_DEV, ST_AHI, ST_ALO, ST_WR: begin
          if (scl_rise && !byte_full) begin
            sh_d  = {sh_q[6:0], sda_f};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && byte_full) begin
            ack_d = 1'b1;
            oe_d  = 1'b1;
            case (st_q)
              ST_DEV: begin
                if (!dev_ok) begin
                  ack_d = 1'b0;
                  oe_d  = 1'b0;
                  st_d  = ST_IDLE;
                end else begin
                  st_d = sh_q[0] ? ST_RD : ST_AHI;
                end
              end
              ST_AHI: begin
                hi_d = sh_q;
                st_d = ST_ALO;
              end
              ST_ALO: begin
                p_load = 1'b1;
                st_d   = ST_WR;
              end
              default: begin
                wv_d   = 1'b1;
                wa_d   = ptr;
                wd_d   = sh_q;
                p_page = 1'b1;
                any_d  = 1'b1;
              end
            endcase
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (byte_full) begin
              oe_d = 1'b0;
              st_d = ST_MACK;
            end else begin
              sh_d = {sh_q[6:0], 1'b0};
              oe_d = !sh_q[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_d = !sda_f;
            p_full = 1'b1;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_d  = ST_RD;
              cnt_d = '0;
              sh_d  = rd_data_i;
              oe_d  = !rd_data_i[7];
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      sh_q     <= '0;
      hi_q     <= '0;
      cnt_q    <= '0;
      ack_q    <= 1'b0;
      oe_q     <= 1'b0;
      any_q    <= 1'b0;
      mack_q   <= 1'b0;
      wv_q     <= 1'b0;
      wa_q     <= '0;
      wd_q     <= '0;
      commit_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      sh_q     <= sh_d;
      hi_q     <= hi_d;
      cnt_q    <= cnt_d;
      ack_q    <= ack_d;
      oe_q     <= oe_d;
      any_q    <= any_d;
      mack_q   <= mack_d;
      wv_q     <= wv_d;
      wa_q     <= wa_d;
      wd_q     <= wd_d;
      commit_q <= commit_d;
    end
  end

  assign sda_oe_o    = oe_q;
  assign rd_addr_o   = ptr;
  assign wr_valid_o  = wv_q;
  assign wr_addr_o   = wa_q;
  assign wr_data_o   = wd_q;
  assign wr_commit_o = commit_q;

  AST_DRIVE_ONLY_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q != $past(oe_q)) |-> !scl_f); // R12
  AST_BUSY_BLOCKS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ack_q) && ($past(st_q) == ST_DEV)) |-> !$past(busy_i)); // R4
  AST_ACK_NEEDS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ack_q) && ($past(st_q) == ST_DEV)) |->
      (($past(sh_q[7:4]) == 4'b1010) && ($past(sh_q[3:1]) == $past(strap_i)))); // R3
  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |-> $past(stop_ev)); // R7
  AST_WR_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o); // R6
  AST_RELEASED_IN_MACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_MACK) |-> !oe_q); // R11
endmodule

// File: tb/smi_target_tb.sv
`timescale 1ns/1ps
module smi_target_tb;
  localparam int AW = 12;
  localparam int Q  = 30;   // quarter bit in core clocks
  localparam int GL = 5;    // spike length, below the filter length
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DW = 8'hAA;  // 1010_101_0
  localparam logic [7:0] DR = 8'hAB;  // 1010_101_1

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic sda_oe, wr_valid, wr_commit;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic sda_line;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign rd_data  = rd_addr[7:0] ^ {rd_addr[11:8], rd_addr[11:8]} ^ 8'h5A;

  smi_target #(.ADDR_W(AW), .PAGE_BYTES(32), .FILT_N(13)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .strap_i     (STRAP),
    .busy_i      (busy),
    .rd_data_i   (rd_data),
    .sda_oe_o    (sda_oe),
    .rd_addr_o   (rd_addr),
    .wr_valid_o  (wr_valid),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .wr_commit_o (wr_commit)
  );

  int n_chk = 0, n_bad = 0, n_commit = 0, exp_commit = 0, ref_ptr = 0;
  int exp_wq[$];

  function automatic int mem_val(int a);
    logic [11:0] x;
    x = 12'(a);
    return int'(x[7:0] ^ {x[11:8], x[11:8]} ^ 8'h5A);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference: every presented write byte is compared on the clock it appears
  always @(negedge clk) begin
    if (rst_ni) begin
      if (wr_valid) begin
        if (exp_wq.size() == 0) chk("R6 unexpected write byte", 32'({wr_addr, wr_data}), 32'hFFFFFFFF);
        else chk("R6 write byte addr/data", 32'({wr_addr, wr_data}), 32'(exp_wq.pop_front()));
      end
      if (wr_commit) n_commit++;
    end
  end

  task automatic bit_xfer(input logic b, output logic s);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(Q);
    s = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack_low);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(v[i], s);
    bit_xfer(1'b1, s);
    ack_low = !s;
  endtask

  task automatic send_byte_spiky(input logic [7:0] v, output logic ack_low);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      if (i == 5) begin
        sda_m = v[i]; tick(Q / 2);
        scl_m = 1'b1; tick(GL); scl_m = 1'b0; tick(Q - Q / 2 - GL);
        scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
      end else if (i == 2) begin
        sda_m = v[i]; tick(Q);
        scl_m = 1'b1; tick(Q / 2);
        sda_m = ~v[i]; tick(GL); sda_m = v[i]; tick(Q - Q / 2 - GL);
        tick(Q); scl_m = 1'b0; tick(Q);
      end else begin
        bit_xfer(v[i], s);
      end
    end
    bit_xfer(1'b1, s);
    ack_low = !s;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, s);
      v[i] = s;
    end
    bit_xfer(!m_ack, s);
  endtask

  task automatic do_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic do_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  // write transaction with n data bytes d0, d0+step, ...
  task automatic wr_txn(input logic [7:0] hi, input logic [7:0] lo, input int n,
                        input logic [7:0] d0, input logic [7:0] step, input bit spiky);
    logic a;
    int addr;
    logic [7:0] d;
    do_start;
    send_byte(DW, a); chk("R3 write device word ack", 32'(a), 32'd1);
    send_byte(hi, a); chk("R5 high address ack", 32'(a), 32'd1);
    send_byte(lo, a); chk("R5 low address ack", 32'(a), 32'd1);
    addr = int'({hi, lo}) & 32'hFFF;
    d = d0;
    for (int k = 0; k < n; k++) begin
      exp_wq.push_back(addr * 256 + int'(d));
      if (spiky) send_byte_spiky(d, a);
      else send_byte(d, a);
      chk("R6 data byte ack", 32'(a), 32'd1);
      addr = (addr & ~31) | ((addr + 1) & 31);
      d = d + step;
    end
    do_stop;
    if (n > 0) exp_commit++;
    ref_ptr = addr;
    tick(Q);
    chk("R7 commit count after stop", 32'(n_commit), 32'(exp_commit));
    chk("R6 all write bytes seen", 32'(exp_wq.size()), 32'd0);
    chk("R8 pointer after write", 32'(rd_addr), 32'(ref_ptr));
  endtask

  task automatic cur_read(input string req);
    logic a;
    logic [7:0] v;
    do_start;
    send_byte(DR, a); chk("R3 read device word ack", 32'(a), 32'd1);
    recv_byte(1'b0, v); chk(req, 32'(v), 32'(mem_val(ref_ptr)));
    do_stop;
    ref_ptr = (ref_ptr + 1) & 32'hFFF;
  endtask

  initial begin
    logic a;
    logic [7:0] v;
    logic s;
    int ones;

    tick(10);
    // reset state
    chk("R8 reset drive released", 32'(sda_oe), 32'd0);
    chk("R8 reset no write pulse", 32'(wr_valid), 32'd0);
    chk("R8 reset no commit", 32'(wr_commit), 32'd0);
    chk("R8 reset pointer", 32'(rd_addr), 32'd0);
    rst_ni = 1'b1;
    tick(10);

    // R8: current-address read straight after reset uses address 0
    cur_read("R8 current read after reset");
    chk("R8 pointer after read", 32'(rd_addr), 32'(ref_ptr));

    // R3: wrong device code, then wrong strap bits
    do_start; send_byte(8'hBA, a); chk("R3 wrong code not acked", 32'(a), 32'd0); do_stop;
    do_start; send_byte(8'hA4, a); chk("R3 wrong strap not acked", 32'(a), 32'd0); do_stop;
    chk("R3 pointer untouched by foreign word", 32'(rd_addr), 32'(ref_ptr));

    // R5/R6/R7: single byte write
    wr_txn(8'h01, 8'h23, 1, 8'h3C, 8'h00, 1'b0);
    // R5: top bits of high address byte are ignored
    wr_txn(8'hF3, 8'h40, 1, 8'h77, 8'h00, 1'b0);
    // R6: page write wraps within the 32-byte page
    wr_txn(8'h00, 8'h5E, 4, 8'h11, 8'h11, 1'b0);
    cur_read("R8 read after page wrap");

    // R1: spikes on clock and data inside a data byte are filtered
    wr_txn(8'h02, 8'h00, 1, 8'hA5, 8'h00, 1'b1);

    // R4: busy refuses both directions, then acknowledges once idle
    busy = 1'b1;
    do_start; send_byte(DW, a); chk("R4 write word refused while busy", 32'(a), 32'd0); do_stop;
    do_start; send_byte(DR, a); chk("R4 read word refused while busy", 32'(a), 32'd0); do_stop;
    busy = 1'b0;
    do_start; send_byte(DW, a); chk("R4 write word acked when idle", 32'(a), 32'd1); do_stop;
    tick(Q);
    chk("R7 no commit without data", 32'(n_commit), 32'(exp_commit));

    // R9/R10: random read near the array end, sequential across the wrap
    do_start;
    send_byte(DW, a); chk("R9 dummy write device ack", 32'(a), 32'd1);
    send_byte(8'h0F, a); chk("R9 high address ack", 32'(a), 32'd1);
    send_byte(8'hFE, a); chk("R9 low address ack", 32'(a), 32'd1);
    do_start;
    send_byte(DR, a); chk("R9 read device ack after repeated start", 32'(a), 32'd1);
    recv_byte(1'b1, v); chk("R9 random read data", 32'(v), 32'(mem_val(12'hFFE)));
    recv_byte(1'b1, v); chk("R10 sequential next byte", 32'(v), 32'(mem_val(12'hFFF)));
    recv_byte(1'b1, v); chk("R10 sequential wrap to 0", 32'(v), 32'(mem_val(0)));
    recv_byte(1'b0, v); chk("R10 sequential after wrap", 32'(v), 32'(mem_val(1)));
    do_stop;
    ref_ptr = 2;
    tick(Q);
    chk("R7 dummy write does not commit", 32'(n_commit), 32'(exp_commit));
    cur_read("R8 current read after sequential");

    // R2: start in the middle of a byte aborts it
    do_start;
    bit_xfer(1'b1, s); bit_xfer(1'b0, s); bit_xfer(1'b1, s); bit_xfer(1'b0, s);
    do_start;
    send_byte(DR, a); chk("R2 device ack after abort", 32'(a), 32'd1);
    recv_byte(1'b0, v); chk("R2 read after abort", 32'(v), 32'(mem_val(ref_ptr)));
    do_stop;
    ref_ptr = ref_ptr + 1;

    // R11: no-acknowledge without stop leaves the line released
    do_start;
    send_byte(DR, a); chk("R11 device ack", 32'(a), 32'd1);
    recv_byte(1'b0, v); chk("R11 read byte", 32'(v), 32'(mem_val(ref_ptr)));
    ref_ptr = ref_ptr + 1;
    ones = 0;
    for (int i = 0; i < 8; i++) begin
      bit_xfer(1'b1, s);
      if (s) ones++;
    end
    chk("R11 line released after nack", 32'(ones), 32'd8);
    do_stop;
    cur_read("R11 pointer after released read");

    tick(20);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired: actual=hang expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule